// File: doc/BRIEF.md
# FIFO Fill-Level Threshold Interrupt Unit

This unit watches four queue fill levels in a network controller: free space in the transmit data queue, occupancy of the transmit status queue, free space in the receive data queue and occupancy of the receive status queue. A single 32-bit threshold word holds one 8-bit limit for each source. On every clock the unit compares each level against its limit and latches a sticky status flag whenever the condition holds.

The two data queue levels arrive as byte counts. The unit converts each one to 64-byte blocks by dropping the low six bits, so any partial block is discarded. The two status queue levels arrive as word counts and are compared without any conversion. Three sources fire when the level is strictly above the limit. Receive data free space fires when it is strictly below its limit, which warns the host that the receive side is running out of room.

The host clears a flag by writing a 1 to its position. A separate 4-bit enable register chooses which flags drive the single interrupt output.

Top module: `fifo_level_irq`

## Requirements
- R1: After reset `cfg_q` reads 0x4800_0000, `stat` reads 0, `en_q` reads 0 and `irq` is low.
- R2: A cycle with `cfg_wr` high stores `cfg_wr_data` in the threshold word, visible on `cfg_q` after that clock edge. The fields are: bits 31:24 transmit data limit, bits 23:16 transmit status limit, bits 15:8 receive data limit, bits 7:0 receive status limit.
- R3: `stat[3]` sets at the next edge when `tx_data_free_bytes >> 6` is strictly greater than `cfg_q[31:24]`.
- R4: `stat[2]` sets at the next edge when `tx_stat_used` is strictly greater than `cfg_q[23:16]`.
- R5: `stat[1]` sets at the next edge when `rx_data_free_bytes >> 6` is strictly less than `cfg_q[15:8]`.
- R6: `stat[0]` sets at the next edge when `rx_stat_used` is strictly greater than `cfg_q[7:0]`.
- R7: A set flag stays set after its condition goes away. It clears only at an edge where `clr_wr` is high and the matching bit of `clr_data` is 1. Writing a 0 to a bit leaves that flag unchanged.
- R8: If a flag's condition holds in the same cycle that the host clears it, the flag stays set.
- R9: `irq` equals the OR of `stat & en_q`. A cycle with `en_wr` high loads `en_data` into `en_q` at the next edge.
- R10: Conversion from bytes to blocks truncates. For example, 4671 bytes counts as 72 blocks and 191 bytes counts as 2 blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data_free_bytes | input | DBYTE_W | Transmit data queue free space, in bytes |
| tx_stat_used | input | SCNT_W | Transmit status queue occupancy, in words |
| rx_data_free_bytes | input | DBYTE_W | Receive data queue free space, in bytes |
| rx_stat_used | input | SCNT_W | Receive status queue occupancy, in words |
| cfg_wr | input | 1 | Threshold word write strobe |
| cfg_wr_data | input | 32 | Threshold word write value |
| cfg_q | output | 32 | Current threshold word |
| en_wr | input | 1 | Enable register write strobe |
| en_data | input | 4 | Enable register write value |
| en_q | output | 4 | Current per-source enables |
| clr_wr | input | 1 | Status clear strobe |
| clr_data | input | 4 | Write-one-to-clear mask |
| stat | output | 4 | Sticky flags: 3 tx data, 2 tx status, 1 rx data, 0 rx status |
| irq | output | 1 | Combined interrupt |

## Verification
A level change appears in `stat` at the first clock edge after it is driven. A threshold write needs one edge to reach `cfg_q`, and the new limit affects a flag one edge after that. `irq` follows `stat` and `en_q` with no extra delay, so it changes in the same cycle as the register it depends on. The bench drives every input on the falling edge. It then waits for one rising edge and samples on the following falling edge. Where a limit write comes before a level change, it spends one extra cycle for the limit write.

// File: rtl/fifo_level_irq.sv
module fifo_level_irq #(
  parameter int DBYTE_W = 16,
  parameter int SCNT_W  = 16,
  parameter logic [31:0] CFG_RST = 32'h4800_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DBYTE_W-1:0] tx_data_free_bytes,
  input  logic [SCNT_W-1:0]  tx_stat_used,
  input  logic [DBYTE_W-1:0] rx_data_free_bytes,
  input  logic [SCNT_W-1:0]  rx_stat_used,
  input  logic               cfg_wr,
  input  logic [31:0]        cfg_wr_data,
  output logic [31:0]        cfg_q,
  input  logic               en_wr,
  input  logic [3:0]         en_data,
  output logic [3:0]         en_q,
  input  logic               clr_wr,
  input  logic [3:0]         clr_data,
  output logic [3:0]         stat,
  output logic               irq
);
  localparam int BLK_W  = DBYTE_W - 6;
  localparam int DCMP_W = (BLK_W > 8) ? BLK_W : 8;
  localparam int SCMP_W = (SCNT_W > 8) ? SCNT_W : 8;

  logic [DCMP_W-1:0] tx_blk, rx_blk, tx_lim, rx_lim;
  logic [SCMP_W-1:0] txs_cnt, rxs_cnt, txs_lim, rxs_lim;
  logic [3:0] hit, clr_mask;

  assign tx_blk  = DCMP_W'(tx_data_free_bytes[DBYTE_W-1:6]);
  assign rx_blk  = DCMP_W'(rx_data_free_bytes[DBYTE_W-1:6]);
  assign tx_lim  = DCMP_W'(cfg_q[31:24]);
  assign rx_lim  = DCMP_W'(cfg_q[15:8]);
  assign txs_cnt = SCMP_W'(tx_stat_used);
  assign rxs_cnt = SCMP_W'(rx_stat_used);
  assign txs_lim = SCMP_W'(cfg_q[23:16]);
  assign rxs_lim = SCMP_W'(cfg_q[7:0]);

  assign hit[3] = tx_blk  > tx_lim;
  assign hit[2] = txs_cnt > txs_lim;
  assign hit[1] = rx_blk  < rx_lim;
  assign hit[0] = rxs_cnt > rxs_lim;

  assign clr_mask = clr_wr ? clr_data : 4'b0000;
  assign irq      = |(stat & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      en_q  <= '0;
      stat  <= '0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_wr_data;
      if (en_wr)  en_q  <= en_data;
      stat <= (stat & ~clr_mask) | hit;
    end
  end
endmodule

// File: rtl/fifo_level_irq_chk.sv
module fifo_level_irq_chk #(
  parameter int DBYTE_W = 16,
  parameter int SCNT_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DBYTE_W-1:0] tx_data_free_bytes,
  input logic [SCNT_W-1:0]  tx_stat_used,
  input logic [DBYTE_W-1:0] rx_data_free_bytes,
  input logic [SCNT_W-1:0]  rx_stat_used,
  input logic               cfg_wr,
  input logic [31:0]        cfg_wr_data,
  input logic [31:0]        cfg_q,
  input logic               en_wr,
  input logic [3:0]         en_data,
  input logic [3:0]         en_q,
  input logic               clr_wr,
  input logic [3:0]         clr_data,
  input logic [3:0]         stat,
  input logic               irq
);
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_q == $past(cfg_wr_data));

  assert_txdata_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_data_free_bytes >> 6) > 32'(cfg_q[31:24])) |=> stat[3]);

  assert_txstat_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_stat_used) > 32'(cfg_q[23:16])) |=> stat[2]);

  assert_rxdata_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rx_data_free_bytes >> 6) < 32'(cfg_q[15:8])) |=> stat[1]);

  assert_rxstat_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rx_stat_used) > 32'(cfg_q[7:0])) |=> stat[0]);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !(clr_wr && clr_data[0])) |=> stat[0]);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(stat & en_q));

  assert_en_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en_q == $past(en_data));
endmodule

bind fifo_level_irq fifo_level_irq_chk #(.DBYTE_W(DBYTE_W), .SCNT_W(SCNT_W)) i_chk (.*);

// File: tb/test_fifo_level_irq.sv
module test_fifo_level_irq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] tx_data_free_bytes = '0, tx_stat_used = '0;
  logic [15:0] rx_data_free_bytes = 16'hFFFF, rx_stat_used = '0;
  logic cfg_wr = 1'b0, en_wr = 1'b0, clr_wr = 1'b0;
  logic [31:0] cfg_wr_data = '0, cfg_q;
  logic [3:0] en_data = '0, en_q, clr_data = '0, stat;
  logic irq;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_level_irq i_fifo_level_irq (.*);

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear(logic [3:0] m);
    clr_wr = 1'b1; clr_data = m; step(); clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg_q, 32'h4800_0000);
    chk("R1 stat", 32'(stat), 0);
    chk("R1 en", 32'(en_q), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_txdata();
    tx_data_free_bytes = 16'd4608; step();
    chk("R3 equal", 32'(stat[3]), 0);
    tx_data_free_bytes = 16'd4671; step();
    chk("R10 trunc", 32'(stat[3]), 0);
    tx_data_free_bytes = 16'd4672; step();
    chk("R3 above", 32'(stat[3]), 1);
    tx_data_free_bytes = 16'd0; clear(4'b1000);
    chk("R7 clear", 32'(stat), 0);
  endtask

  task automatic t_cfg();
    cfg_wr = 1'b1; cfg_wr_data = 32'h0102_0304; step(); cfg_wr = 1'b0;
    chk("R2 load", cfg_q, 32'h0102_0304);
    chk("R2 nohit", 32'(stat), 0);
  endtask

  task automatic t_txstat();
    tx_stat_used = 16'd2; step();
    chk("R4 equal", 32'(stat[2]), 0);
    tx_stat_used = 16'd3; step();
    chk("R4 above", 32'(stat[2]), 1);
    tx_stat_used = 16'd0; clear(4'b0100);
    chk("R4 clear", 32'(stat), 0);
  endtask

  task automatic t_rxdata();
    rx_data_free_bytes = 16'd192; step();
    chk("R5 equal", 32'(stat[1]), 0);
    rx_data_free_bytes = 16'd191; step();
    chk("R5 R10 below", 32'(stat[1]), 1);
    rx_data_free_bytes = 16'hFFFF; clear(4'b0010);
    chk("R5 clear", 32'(stat), 0);
  endtask

  task automatic t_rxstat_sticky();
    rx_stat_used = 16'd4; step();
    chk("R6 equal", 32'(stat[0]), 0);
    rx_stat_used = 16'd5; step();
    chk("R6 above", 32'(stat[0]), 1);
    rx_stat_used = 16'd0; step(); step();
    chk("R7 hold", 32'(stat), 1);
    clear(4'b1110);
    chk("R7 zero bits", 32'(stat), 1);
    clr_wr = 1'b0; clr_data = 4'b0001; step(); clr_data = '0;
    chk("R7 no strobe", 32'(stat), 1);
    clear(4'b0001);
    chk("R7 w1c", 32'(stat), 0);
  endtask

  task automatic t_setwins();
    rx_stat_used = 16'd5; step();
    clear(4'b0001);
    chk("R8 set wins", 32'(stat[0]), 1);
    rx_stat_used = 16'd0;
  endtask

  task automatic t_irq();
    chk("R9 masked", 32'(irq), 0);
    en_wr = 1'b1; en_data = 4'b0001; step(); en_wr = 1'b0;
    chk("R9 en", 32'(en_q), 1);
    chk("R9 irq on", 32'(irq), 1);
    en_wr = 1'b1; en_data = 4'b1110; step(); en_wr = 1'b0;
    chk("R9 other en", 32'(irq), 0);
    en_wr = 1'b1; en_data = 4'b0001; step(); en_wr = 1'b0;
    clear(4'b0001);
    chk("R9 irq off", 32'(irq), 0);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1; step();
    t_reset();
    t_txdata();
    t_cfg();
    t_txstat();
    t_rxdata();
    t_rxstat_sticky();
    t_setwins();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule